// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock timing for an I2C bus master. A fast system clock feeds a prescaler that divides it by one, two or four. The counters of a phase engine then count the resulting operating-clock ticks to time each low and each high half-period of SCL. A 16-bit mode register selects four things: the prescaler ratio, one of three speed classes, a percentage slowdown and whether clock stretching is honoured. Its enable bit gates all activity.

SCL is only ever pulled low, through an open-drain drive enable. Releasing the line means dropping that enable. A one-clock strobe marks every falling edge and every rising edge that the generator makes. A separate byte and condition sequencer uses these strobes to move SDA while SCL is low, and holds the `run` input high for as long as it wants clocks. When stretching is on, the generator passes the sampled SCL level through a two-stage synchronizer. It does not count down a high half-period until the line is actually seen high, so a slave that holds SCL low lengthens the bus cycle.

Top module: `scl_rategen`

## Requirements
- R1: After reset the mode register reads 0x0200. Bits 15:10 and 7:6 always read as zero. Field positions are: bit 0 enable, bits 2:1 speed class, bits 4:3 slowdown, bit 5 stretch, bits 9:8 clock select.
- R2: A write updates bits 9:8 only when byte enable 1 is set, and bits 5:0 only when byte enable 0 is set. Each byte lane is written independently.
- R3: The clock select sets the operating-clock divide ratio: 00 divides by 1, 01 by 2, and 10 or the reserved 11 by 4. Every phase lasts its tick count multiplied by that ratio, in system clocks.
- R4: With no slowdown the speed class sets the low/high tick counts. 00 gives 88/72 ticks, 01 gives 22/18 ticks, and both 10 and 11 give 9/7 ticks.
- R5: Slowdown codes 01, 10 and 11 multiply both tick counts by 1.1, 1.2 and 1.3 respectively, rounded up. Code 00 leaves them unchanged.
- R6: While `slow_src` is high, the slowdown field has no effect and the nominal counts are used.
- R7: With stretch on, a high phase ends no sooner than its tick count after the synchronized SCL level is seen high. With stretch off, the high phase ends after its tick count whatever the line level.
- R8: While the enable bit is 0, SCL is released, no strobe fires and the phase state is cleared. Clearing enable during a low phase releases SCL within two clocks.
- R9: `fall_stb` pulses for one clock in the clock that `scl_drive_low` asserts. `rise_stb` pulses for one clock in the clock that it deasserts during normal operation. The two strobes never fire together.
- R10: When `run` is dropped, the current low phase and its following high phase complete. SCL then stays released and no further falling strobe fires.
- R11: A `run` request made while the enable bit is 0 produces no SCL activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Mode register write strobe |
| reg_be | input | 2 | Byte enables for the write (bit 1 = upper byte) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Mode register read value |
| slow_src | input | 1 | System is running from a low-speed clock source |
| run | input | 1 | Sequencer requests SCL clocking |
| scl_in | input | 1 | Sampled SCL line level (asynchronous) |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| fall_stb | output | 1 | One-clock strobe at each generated SCL falling edge |
| rise_stb | output | 1 | One-clock strobe at each generated SCL release |

## Verification
A wrong divide ratio, count-table entry or slowdown lookup changes the number of clocks between adjacent strobes. The error is therefore visible at the end of the first affected half-period, at most a few hundred clocks after the setting takes effect. A synchronizer or stretch-gating fault shows as a high phase that ends while a slave still holds the line, or that keeps waiting after release, in the first stretched cycle. A stuck phase state or an enable path that fails to clear shows within two clocks as SCL still pulled low, or as strobes appearing while disabled.

// File: rtl/scl_rg_pkg.sv
// Shared types and constant helpers for the SCL rate generator.
// Assumes tick counts are small positive integers.
package scl_rg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       stretch;
        logic [1:0] slow;
        logic [1:0] speed;
        logic       enable;
    } mode_t;

    // Scale n by (10+k)/10, rounded up.
    function automatic int scale_up(input int n, input int k);
        return (n * (10 + k) + 9) / 10;
    endfunction

    // Pick one of three values by index.
    function automatic int pick3(input int idx, input int a, input int b, input int c);
        return (idx == 0) ? a : ((idx == 1) ? b : c);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/scl_rg_regs.sv
// Mode register with byte-lane writes.
// Assumes reserved bits are never stored; they read back as zero.
module scl_rg_regs
    import scl_rg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    output mode_t       mode,
    output logic [15:0] rdata
);

    // Store the writable fields, lane by lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode.clk_sel <= 2'b10;
            mode.stretch <= 1'b0;
            mode.slow    <= 2'b00;
            mode.speed   <= 2'b00;
            mode.enable  <= 1'b0;
        end else if (wr) begin
            if (be[1]) begin
                mode.clk_sel <= wdata[9:8];
            end
            if (be[0]) begin
                mode.stretch <= wdata[5];
                mode.slow    <= wdata[4:3];
                mode.speed   <= wdata[2:1];
                mode.enable  <= wdata[0];
            end
        end
    end

    // Compose the read value with reserved bits forced low.
    always_comb begin
        rdata      = '0;
        rdata[9:8] = mode.clk_sel;
        rdata[5]   = mode.stretch;
        rdata[4:3] = mode.slow;
        rdata[2:1] = mode.speed;
        rdata[0]   = mode.enable;
    end

endmodule

// File: rtl/scl_rg_prescale.sv
// Operating-clock prescaler: emits a one-clock tick every 1, 2 or 4 clocks.
// Assumes select 11 behaves like 10 (divide by four).
module scl_rg_prescale #(
    parameter int MAX_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] clk_sel,
    output logic       tick
);

    localparam int PW = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    // Terminal count for the selected ratio.
    always_comb begin
        case (clk_sel)
            2'b00:   limit = PW'(0);
            2'b01:   limit = PW'(1);
            default: limit = PW'(MAX_DIV - 1);
        endcase
    end

    assign tick = (pcnt >= limit);

    // Free-running divide counter, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PW'(1);
        end
    end

endmodule

// File: rtl/scl_rg_timing.sv
// Half-period count lookup: all speed-class and slowdown combinations are
// computed at elaboration and selected by the mode fields.
// Assumes every base count is at least 1.
module scl_rg_timing
    import scl_rg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int STD_LO = 88,
    parameter int STD_HI = 72,
    parameter int FST_LO = 22,
    parameter int FST_HI = 18,
    parameter int FPL_LO = 9,
    parameter int FPL_HI = 7
) (
    input  logic [1:0]       speed,
    input  logic [1:0]       slow,
    input  logic             slow_src,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hi_cnt
);

    localparam int N_CLASS = 3;
    localparam int N_SLOW  = 4;

    logic [CNT_W-1:0] lo_tab [N_CLASS][N_SLOW];
    logic [CNT_W-1:0] hi_tab [N_CLASS][N_SLOW];
    logic [1:0]       cls;
    logic [1:0]       eff_slow;

    // Build the constant tables.
    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
        for (genvar k = 0; k < N_SLOW; k++) begin : g_slow
            localparam int LO = scale_up(pick3(c, STD_LO, FST_LO, FPL_LO), k);
            localparam int HI = scale_up(pick3(c, STD_HI, FST_HI, FPL_HI), k);
            assign lo_tab[c][k] = CNT_W'(LO);
            assign hi_tab[c][k] = CNT_W'(HI);
        end
    end

    // Map speed field to a class index; 10 and 11 share the top class.
    always_comb begin
        case (speed)
            2'b00:   cls = 2'd0;
            2'b01:   cls = 2'd1;
            default: cls = 2'd2;
        endcase
    end

    // Slowdown is forced off on a low-speed clock source.
    assign eff_slow = slow_src ? 2'b00 : slow;

    // Select the active pair.
    always_comb begin
        lo_cnt = lo_tab[cls][eff_slow];
        hi_cnt = hi_tab[cls][eff_slow];
    end

endmodule

// File: rtl/scl_rg_phase.sv
// SCL phase engine: times low and high half-periods in operating ticks,
// drives the open-drain enable, emits edge strobes and, when stretching is
// on, holds the high count until the synchronized line reads high.
// Assumes counts of at least 1 and that state changes only on a tick.
module scl_rg_phase
    import scl_rg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             run,
    input  logic             stretch,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    output logic             drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);

    phase_e           state;
    logic [CNT_W-1:0] cnt;
    logic             sync1;
    logic             sync2;
    logic             high_ok;

    // Two-stage synchronizer for the sampled SCL line (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= scl_in;
            sync2 <= sync1;
        end
    end

    // High-phase counting is allowed when not stretching or line seen high.
    assign high_ok = !stretch || sync2;

    // Phase sequencing, counter and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state     <= PH_IDLE;
            cnt       <= '0;
            drive_low <= 1'b0;
            fall_stb  <= 1'b0;
            rise_stb  <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (tick && run) begin
                        state     <= PH_LOW;
                        drive_low <= 1'b1;
                        fall_stb  <= 1'b1;
                        cnt       <= lo_cnt - CNT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            state     <= PH_HIGH;
                            drive_low <= 1'b0;
                            rise_stb  <= 1'b1;
                            cnt       <= hi_cnt - CNT_W'(1);
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick && high_ok) begin
                        if (cnt != '0) begin
                            cnt <= cnt - CNT_W'(1);
                        end else if (run) begin
                            state     <= PH_LOW;
                            drive_low <= 1'b1;
                            fall_stb  <= 1'b1;
                            cnt       <= lo_cnt - CNT_W'(1);
                        end else begin
                            state <= PH_IDLE;
                        end
                    end
                end
                default: begin
                    state     <= PH_IDLE;
                    drive_low <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_rategen.sv
// Top of the SCL rate generator: mode register, prescaler, count lookup
// and phase engine. Assumes the sequencer holds run high while it wants
// clocks and that scl_in reflects the wired-AND bus level.
module scl_rategen
    import scl_rg_pkg::*;
#(
    parameter int STD_LO = 88,
    parameter int STD_HI = 72,
    parameter int FST_LO = 22,
    parameter int FST_HI = 18,
    parameter int FPL_LO = 9,
    parameter int FPL_HI = 7,
    parameter int MAX_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        slow_src,
    input  logic        run,
    input  logic        scl_in,
    output logic        scl_drive_low,
    output logic        fall_stb,
    output logic        rise_stb
);

    localparam int MAX_BASE = max3(max3(STD_LO, STD_HI, FST_LO),
                                   max3(FST_HI, FPL_LO, FPL_HI), 1);
    localparam int CNT_W    = $clog2(scale_up(MAX_BASE, 3) + 1);

    mode_t            mode;
    logic             tick;
    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;

    scl_rg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .be    (reg_be),
        .wdata (reg_wdata),
        .mode  (mode),
        .rdata (reg_rdata)
    );

    scl_rg_prescale #(.MAX_DIV(MAX_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode.enable),
        .clk_sel (mode.clk_sel),
        .tick    (tick)
    );

    scl_rg_timing #(
        .CNT_W (CNT_W),
        .STD_LO(STD_LO), .STD_HI(STD_HI),
        .FST_LO(FST_LO), .FST_HI(FST_HI),
        .FPL_LO(FPL_LO), .FPL_HI(FPL_HI)
    ) u_tim (
        .speed    (mode.speed),
        .slow     (mode.slow),
        .slow_src (slow_src),
        .lo_cnt   (lo_cnt),
        .hi_cnt   (hi_cnt)
    );

    scl_rg_phase #(.CNT_W(CNT_W)) u_ph (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode.enable),
        .tick      (tick),
        .run       (run),
        .stretch   (mode.stretch),
        .scl_in    (scl_in),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .drive_low (scl_drive_low),
        .fall_stb  (fall_stb),
        .rise_stb  (rise_stb)
    );

endmodule

// File: rtl/scl_rategen_chk.sv
// Port-level property checker for scl_rategen, attached by bind.
module scl_rategen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] reg_rdata,
    input logic        scl_drive_low,
    input logic        fall_stb,
    input logic        rise_stb
);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15:10] == 6'd0) && (reg_rdata[7:6] == 2'd0));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb}));

    // R9
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

    // R9
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (!scl_drive_low && $past(scl_drive_low)));

    // R9
    drive_strobed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((scl_drive_low != $past(scl_drive_low)) && reg_rdata[0])
            |-> (fall_stb || rise_stb));

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |=> (!scl_drive_low && !fall_stb && !rise_stb));

endmodule

bind scl_rategen scl_rategen_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rdata     (reg_rdata),
    .scl_drive_low (scl_drive_low),
    .fall_stb      (fall_stb),
    .rise_stb      (rise_stb)
);

// File: tb/scl_rategen_tb_top.sv
`timescale 1ns/1ps
module scl_rategen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        slow_src = 1'b0;
    logic        run = 1'b0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_drive_low;
    logic        fall_stb;
    logic        rise_stb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Wired-AND bus: pulled low by the master or by a stretching slave.
    assign scl_in = !(scl_drive_low || hold);

    scl_rategen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_src(slow_src),
        .run(run), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00;
    endtask

    function automatic logic [15:0] mword(input int cd, input int syn, input int dw,
                                          input int md, input int en);
        return 16'((cd << 8) | (syn << 5) | (dw << 3) | (md << 1) | en);
    endfunction

    function automatic int scaled(input int n, input int k);
        return (n * (10 + k) + 9) / 10;
    endfunction

    // Measure one low phase and the following high phase in system clocks.
    task automatic measure(output int lo, output int hi);
        int n = 0;
        while (!fall_stb && n < 5000) begin @(negedge clk); n++; end
        lo = 0;
        do begin @(negedge clk); lo++; end while (!rise_stb && lo < 5000);
        hi = 0;
        do begin @(negedge clk); hi++; end while (!fall_stb && hi < 5000);
    endtask

    task automatic stop_all();
        run = 1'b0;
        write_reg(2'b11, 16'h0000);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(reg_rdata == 16'h0200, "R1 reset value", reg_rdata, 16'h0200);
        check(!scl_drive_low && !fall_stb && !rise_stb, "R1 idle after reset",
              {scl_drive_low, fall_stb, rise_stb}, 0);
    endtask

    task automatic t_bytes();
        write_reg(2'b01, 16'hFFFF);
        @(negedge clk);
        check(reg_rdata == 16'h023F, "R2 low lane only", reg_rdata, 16'h023F);
        write_reg(2'b10, 16'h01C0);
        @(negedge clk);
        check(reg_rdata == 16'h013F, "R2 high lane only, R1 reserved zero", reg_rdata, 16'h013F);
        write_reg(2'b11, 16'hFFFF);
        @(negedge clk);
        check(reg_rdata == 16'h033F, "R1 reserved bits read zero", reg_rdata, 16'h033F);
        stop_all();
    endtask

    task automatic t_rate(input string tag, input int cd, input int md, input int dw,
                          input bit ss, input int lo_t, input int hi_t, input int div);
        int lo, hi;
        slow_src = ss;
        write_reg(2'b11, mword(cd, 0, dw, md, 1));
        run = 1'b1;
        measure(lo, hi);
        check(lo == lo_t * div, {tag, " low"}, lo, lo_t * div);
        check(hi == hi_t * div, {tag, " high"}, hi, hi_t * div);
        stop_all();
        slow_src = 1'b0;
    endtask

    task automatic t_stretch();
        int lo, hi, n;
        // stretch on: slave holds SCL low 30 clocks after release (R7)
        write_reg(2'b11, mword(0, 1, 0, 2, 1));
        run = 1'b1;
        n = 0;
        while (!fall_stb && n < 5000) begin @(negedge clk); n++; end
        lo = 0;
        do begin @(negedge clk); lo++; end while (!rise_stb && lo < 5000);
        hold = 1'b1;
        hi = 0;
        repeat (30) begin @(negedge clk); hi++;
            check(!fall_stb, "R7 no fall while stretched", fall_stb, 0); end
        hold = 1'b0;
        do begin @(negedge clk); hi++; end while (!fall_stb && hi < 5000);
        check(hi >= 37 && hi <= 41, "R7 stretched high length", hi, 39);
        stop_all();
        // stretch off: the same hold must not lengthen the high phase (R7)
        write_reg(2'b11, mword(0, 0, 0, 2, 1));
        run = 1'b1;
        n = 0;
        while (!rise_stb && n < 5000) begin @(negedge clk); n++; end
        hold = 1'b1;
        hi = 0;
        do begin @(negedge clk); hi++; end while (!fall_stb && hi < 5000);
        hold = 1'b0;
        check(hi == 7, "R7 stretch off ignores line", hi, 7);
        stop_all();
    endtask

    task automatic t_stop();
        int n = 0;
        int seen = 0;
        write_reg(2'b11, mword(0, 0, 0, 1, 1));
        run = 1'b1;
        while (!fall_stb && n < 5000) begin @(negedge clk); n++; end
        run = 1'b0;
        n = 0;
        while (!rise_stb && n < 200) begin @(negedge clk); n++; end
        check(n == 22, "R10 low phase completes after run drop", n, 22);
        repeat (200) begin @(negedge clk); if (fall_stb || scl_drive_low) seen++; end
        check(seen == 0, "R10 no further clocks after stop", seen, 0);
        stop_all();
    endtask

    task automatic t_disable();
        int seen = 0;
        int n = 0;
        run = 1'b1;
        write_reg(2'b11, mword(0, 0, 0, 2, 0));
        repeat (200) begin @(negedge clk); if (fall_stb || rise_stb || scl_drive_low) seen++; end
        check(seen == 0, "R11 run ignored while disabled", seen, 0);
        write_reg(2'b11, mword(0, 0, 0, 0, 1));
        while (!fall_stb && n < 5000) begin @(negedge clk); n++; end
        repeat (5) @(negedge clk);
        check(scl_drive_low, "R8 low phase in progress", scl_drive_low, 1);
        write_reg(2'b01, mword(0, 0, 0, 0, 0));
        @(negedge clk);
        check(!scl_drive_low, "R8 release after disable", scl_drive_low, 0);
        seen = 0;
        repeat (300) begin @(negedge clk); if (fall_stb || rise_stb || scl_drive_low) seen++; end
        check(seen == 0, "R8 silent while disabled", seen, 0);
        run = 1'b0;
        stop_all();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_rate("R4 standard", 0, 0, 0, 0, 88, 72, 1);
        t_rate("R4 fast", 0, 1, 0, 0, 22, 18, 1);
        t_rate("R4 class 10", 0, 2, 0, 0, 9, 7, 1);
        t_rate("R4 class 11", 0, 3, 0, 0, 9, 7, 1);
        t_rate("R3 divide 2", 1, 1, 0, 0, 22, 18, 2);
        t_rate("R3 divide 4", 2, 1, 0, 0, 22, 18, 4);
        t_rate("R3 reserved divide 4", 3, 1, 0, 0, 22, 18, 4);
        t_rate("R5 slow 10pct", 0, 2, 1, 0, scaled(9, 1), scaled(7, 1), 1);
        t_rate("R5 slow 20pct", 0, 2, 2, 0, scaled(9, 2), scaled(7, 2), 1);
        t_rate("R5 slow 30pct", 0, 2, 3, 0, scaled(9, 3), scaled(7, 3), 1);
        t_rate("R5 std slow 30pct", 0, 0, 3, 0, scaled(88, 3), scaled(72, 3), 1);
        t_rate("R6 low-speed source", 0, 1, 3, 1, 22, 18, 1);
        t_stretch();
        t_stop();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule